// File: doc/BRIEF.md
# Maskable Interrupt Aggregation Register

This block collects five event flags from a network controller (missed frame, memory error, receive done, transmit done, initialization done) and folds them into a single interrupt request line. Each flag has a mask bit. A masked flag still records its event, but it does not drive the request line. The host reads the flags and clears them by writing ones. The request line is registered, so it follows the unmasked flags one clock later.

The mask bits and two transmit/receive control bits live in one 32-bit control word. The host writes that word through a plain write strobe and reads it back combinationally. The two control bits are an underflow-recovery enable and a look-ahead receive enable. Both are exported as level signals to neighbouring logic.

Three reset paths act differently:
- A hardware reset (asynchronous, active low) clears everything.
- A synchronous software reset clears everything.
- A synchronous STOP clears the event flags and the request line, but leaves the control word alone.

Top module: `irq_agg_reg`

## Requirements
- R1: While and after hardware reset, the control word reads 0x00000000, all event flags are 0, the request line is 0 and both control outputs are 0.
- R2: Mask bits sit in the control word at bit 8 (init done, flag index 0), bit 9 (transmit, index 1), bit 10 (receive, index 2), bit 11 (memory error, index 3) and bit 12 (missed frame, index 4). A write stores them, and they read back from the cycle after the write.
- R3: Bits 31..13, bit 7 and bits 4..0 of the control word always read as 0, whatever was written to them.
- R4: Bit 6 (underflow-recovery enable) and bit 5 (look-ahead enable) are stored by a write, read back at those positions, and drive `uflo_recover_en` and `lookahead_en` as levels.
- R5: A one-cycle pulse on `evt_set[i]` makes flag i read 1 from the next cycle. This happens whether or not the flag is masked.
- R6: Writing 1 to a flag through `flag_clr_en`/`flag_clr_bits` clears that flag on the next cycle. Writing 0 leaves the flag unchanged. A set pulse in the same cycle as a clear of the same flag wins, and the flag stays 1.
- R7: `irq_out` equals the OR over all flags of (flag AND NOT mask), as sampled one cycle earlier.
- R8: A software reset pulse clears the mask bits, both control bits, all flags and `irq_out` on the next cycle.
- R9: A STOP pulse clears all flags and `irq_out` on the next cycle, and leaves the mask bits and both control bits unchanged.
- R10: Control-word writes take effect even in a cycle where STOP is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst_n | input | 1 | Asynchronous hardware reset, active low |
| sw_rst | input | 1 | Synchronous software reset pulse |
| stop | input | 1 | Synchronous STOP command pulse |
| wr_en | input | 1 | Control-word write strobe |
| wr_data | input | 32 | Control-word write data |
| rd_data | output | 32 | Control-word read data |
| evt_set | input | 5 | Per-flag event set pulses (index 0 init done .. 4 missed frame) |
| flag_clr_en | input | 1 | Flag write-one-to-clear strobe |
| flag_clr_bits | input | 5 | Flags to clear when the strobe is high |
| flags | output | 5 | Current event flags |
| irq_out | output | 1 | Combined registered interrupt request |
| uflo_recover_en | output | 1 | Underflow-recovery enable level |
| lookahead_en | output | 1 | Look-ahead receive enable level |

## Verification
The bench uses the default build: five flags and a 32-bit control word with the mask field at bit 8. With only five flags, every pairing of mask value and flag pattern can be tried, which is 1024 combinations. For each one, the bench checks that flags latch regardless of the mask and that the request line matches the arithmetic OR of unmasked flags one cycle later. The bench also sweeps all 32 mask values with reserved bits written high and low. It then checks same-cycle set/clear priority, STOP against software reset, and writes that land during a STOP.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int NSRC = 5;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef struct packed {
        src_vec_t mask;
        logic     uflo_rec;
        logic     look_ahead;
    } ctrl_state_t;

    typedef struct packed {
        src_vec_t flags;
    } flag_state_t;

    typedef struct packed {
        logic irq;
    } comb_state_t;

endpackage

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
    import irq_agg_pkg::*;
(
    input  logic     clk,
    input  logic     hw_rst_n,
    input  logic     sw_rst,
    input  logic     wr_en,
    input  src_vec_t wr_mask,
    input  logic     wr_uflo,
    input  logic     wr_look,
    output src_vec_t mask,
    output logic     uflo_rec,
    output logic     look_ahead
);

    ctrl_state_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            ctrl_d.mask       = wr_mask;
            ctrl_d.uflo_rec   = wr_uflo;
            ctrl_d.look_ahead = wr_look;
        end
        if (sw_rst) begin
            ctrl_d = '0;
        end
    end

    always_ff @(posedge clk or negedge hw_rst_n) begin
        if (!hw_rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign mask       = ctrl_q.mask;
    assign uflo_rec   = ctrl_q.uflo_rec;
    assign look_ahead = ctrl_q.look_ahead;

    // R2/R4: a write without software reset is visible next cycle
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (wr_en && !sw_rst) |=> (mask == $past(wr_mask) && uflo_rec == $past(wr_uflo)
                                && look_ahead == $past(wr_look)));

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_agg_pkg::*;
(
    input  logic     clk,
    input  logic     hw_rst_n,
    input  logic     sw_rst,
    input  logic     stop,
    input  src_vec_t evt_set,
    input  logic     clr_en,
    input  src_vec_t clr_bits,
    output src_vec_t flags
);

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_en) begin
            st_d.flags = st_d.flags & ~clr_bits;
        end
        st_d.flags = st_d.flags | evt_set;
        if (sw_rst || stop) begin
            st_d.flags = '0;
        end
    end

    always_ff @(posedge clk or negedge hw_rst_n) begin
        if (!hw_rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.flags;

    // R5/R6: every pulsed flag is set next cycle, even against a clear
    p_set_lands_r5: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (!sw_rst && !stop) |=> ((flags & $past(evt_set)) == $past(evt_set)));

    // R6: cleared flags without a same-cycle set drop next cycle
    p_w1c_r6: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (clr_en && !sw_rst && !stop) |=> ((flags & $past(clr_bits) & ~$past(evt_set)) == '0));

endmodule

// File: rtl/irq_combine.sv
module irq_combine
    import irq_agg_pkg::*;
(
    input  logic     clk,
    input  logic     hw_rst_n,
    input  logic     sw_rst,
    input  logic     stop,
    input  src_vec_t flags,
    input  src_vec_t mask,
    output logic     irq
);

    src_vec_t    live;
    comb_state_t cs_d, cs_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_gate
        assign live[i] = flags[i] & ~mask[i];
    end

    always_comb begin
        cs_d     = cs_q;
        cs_d.irq = |live;
        if (sw_rst || stop) begin
            cs_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge hw_rst_n) begin
        if (!hw_rst_n) begin
            cs_q <= '0;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign irq = cs_q.irq;

    // R7: request follows the unmasked flags one cycle late
    p_irq_track_r7: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (!sw_rst && !stop) |=> (irq == |($past(flags) & ~$past(mask))));

endmodule

// File: rtl/irq_agg_reg.sv
module irq_agg_reg
    import irq_agg_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int MASK_LSB = 8,
    parameter int UFLO_BIT = 6,
    parameter int LA_BIT   = 5
) (
    input  logic              clk,
    input  logic              hw_rst_n,
    input  logic              sw_rst,
    input  logic              stop,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [NSRC-1:0]   evt_set,
    input  logic              flag_clr_en,
    input  logic [NSRC-1:0]   flag_clr_bits,
    output logic [NSRC-1:0]   flags,
    output logic              irq_out,
    output logic              uflo_recover_en,
    output logic              lookahead_en
);

    localparam int MASK_MSB = MASK_LSB + NSRC - 1;
    localparam logic [DATA_W-1:0] LIVE_BITS =
        (((DATA_W'(1) << NSRC) - DATA_W'(1)) << MASK_LSB)
        | (DATA_W'(1) << UFLO_BIT) | (DATA_W'(1) << LA_BIT);

    src_vec_t mask;
    logic     unused_wr_bits;

    assign unused_wr_bits = ^(wr_data & ~LIVE_BITS);

    irq_mask_ctrl u_ctrl (
        .clk        (clk),
        .hw_rst_n   (hw_rst_n),
        .sw_rst     (sw_rst),
        .wr_en      (wr_en),
        .wr_mask    (wr_data[MASK_MSB:MASK_LSB]),
        .wr_uflo    (wr_data[UFLO_BIT]),
        .wr_look    (wr_data[LA_BIT]),
        .mask       (mask),
        .uflo_rec   (uflo_recover_en),
        .look_ahead (lookahead_en)
    );

    irq_flag_bank u_flags (
        .clk      (clk),
        .hw_rst_n (hw_rst_n),
        .sw_rst   (sw_rst),
        .stop     (stop),
        .evt_set  (evt_set),
        .clr_en   (flag_clr_en),
        .clr_bits (flag_clr_bits),
        .flags    (flags)
    );

    irq_combine u_comb (
        .clk      (clk),
        .hw_rst_n (hw_rst_n),
        .sw_rst   (sw_rst),
        .stop     (stop),
        .flags    (flags),
        .mask     (mask),
        .irq      (irq_out)
    );

    always_comb begin
        rd_data                    = '0;
        rd_data[MASK_MSB:MASK_LSB] = mask;
        rd_data[UFLO_BIT]          = uflo_recover_en;
        rd_data[LA_BIT]            = lookahead_en;
    end

    // R9: STOP without a write leaves the control word untouched
    p_stop_keeps_ctrl_r9: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (stop && !sw_rst && !wr_en) |=> $stable(rd_data));

    // R9: STOP empties flags and request
    p_stop_clears_r9: assert property (@(posedge clk) disable iff (!hw_rst_n)
        stop |=> (flags == '0 && !irq_out));

    // R8: software reset empties everything
    p_sw_reset_r8: assert property (@(posedge clk) disable iff (!hw_rst_n)
        sw_rst |=> (rd_data == '0 && flags == '0 && !irq_out));

    // R10: a write during STOP still lands
    p_write_in_stop_r10: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (stop && wr_en && !sw_rst) |=> (rd_data == ($past(wr_data) & LIVE_BITS)));

endmodule

// File: tb/irq_agg_reg_tb.sv
`timescale 1ns/1ps
module irq_agg_reg_tb_top;

    logic        clk = 1'b0;
    logic        hw_rst_n = 1'b0;
    logic        sw_rst = 1'b0;
    logic        stop = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [4:0]  evt_set = '0;
    logic        flag_clr_en = 1'b0;
    logic [4:0]  flag_clr_bits = '0;
    logic [4:0]  flags;
    logic        irq_out;
    logic        uflo_recover_en;
    logic        lookahead_en;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    irq_agg_reg dut_i (
        .clk(clk), .hw_rst_n(hw_rst_n), .sw_rst(sw_rst), .stop(stop),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .evt_set(evt_set), .flag_clr_en(flag_clr_en), .flag_clr_bits(flag_clr_bits),
        .flags(flags), .irq_out(irq_out),
        .uflo_recover_en(uflo_recover_en), .lookahead_en(lookahead_en)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic write_ctrl(input logic [31:0] d);
        wr_en = 1'b1; wr_data = d;
        cyc();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse_stop();
        stop = 1'b1;
        cyc();
        stop = 1'b0;
    endtask

    initial begin
        logic [31:0] exp_rd;
        logic        exp_irq;
        cyc(); cyc();
        // R1: reset state
        chk(rd_data == 32'h0, "R1 rd", rd_data, 32'h0);
        chk(flags == 5'h0 && !irq_out, "R1 flags/irq", {26'h0, irq_out, flags}, 32'h0);
        chk(!uflo_recover_en && !lookahead_en, "R1 ctrl", {uflo_recover_en, lookahead_en}, 32'h0);
        hw_rst_n = 1'b1;
        cyc();
        chk(rd_data == 32'h0, "R1 after release", rd_data, 32'h0);

        // R2 R3 R4: mask field sweep with reserved bits high and low
        for (int m = 0; m < 32; m++) begin
            write_ctrl(32'hFFFF_E0FF | (32'(m) << 8));
            exp_rd = (32'(m) << 8) | 32'h60;
            chk(rd_data == exp_rd, "R2/R3 readback high", rd_data, exp_rd);
            chk(uflo_recover_en && lookahead_en, "R4 levels on", {uflo_recover_en, lookahead_en}, 32'h3);
            write_ctrl(32'(m) << 8);
            exp_rd = 32'(m) << 8;
            chk(rd_data == exp_rd, "R2/R3 readback low", rd_data, exp_rd);
            chk(!uflo_recover_en && !lookahead_en, "R4 levels off", {uflo_recover_en, lookahead_en}, 32'h0);
        end
        write_ctrl(32'h40);
        chk(uflo_recover_en && !lookahead_en && rd_data == 32'h40, "R4 bit6 alone", rd_data, 32'h40);
        write_ctrl(32'h20);
        chk(!uflo_recover_en && lookahead_en && rd_data == 32'h20, "R4 bit5 alone", rd_data, 32'h20);

        // R5 R7 R9: every mask against every flag pattern
        for (int m = 0; m < 32; m++) begin
            write_ctrl(32'(m) << 8);
            for (int s = 0; s < 32; s++) begin
                evt_set = 5'(s);
                cyc();
                evt_set = '0;
                chk(flags == 5'(s), "R5 flags latch", {27'h0, flags}, 32'(s));
                cyc();
                exp_irq = |(5'(s) & ~5'(m));
                chk(irq_out == exp_irq, "R7 irq", {31'h0, irq_out}, {31'h0, exp_irq});
                pulse_stop();
                chk(flags == 5'h0 && !irq_out, "R9 stop clears", {26'h0, irq_out, flags}, 32'h0);
                chk(rd_data == (32'(m) << 8), "R9 stop keeps mask", rd_data, 32'(m) << 8);
            end
        end

        // R6: write-one-to-clear and set priority
        write_ctrl(32'h0);
        evt_set = 5'h1F; cyc(); evt_set = '0;
        flag_clr_en = 1'b1; flag_clr_bits = 5'b00101; cyc();
        flag_clr_en = 1'b0; flag_clr_bits = '0;
        chk(flags == 5'b11010, "R6 w1c", {27'h0, flags}, 32'h1A);
        flag_clr_en = 1'b1; flag_clr_bits = 5'b11000; evt_set = 5'b01000; cyc();
        flag_clr_en = 1'b0; flag_clr_bits = '0; evt_set = '0;
        chk(flags == 5'b01010, "R6 set wins", {27'h0, flags}, 32'h0A);
        flag_clr_en = 1'b1; flag_clr_bits = 5'b00000; cyc(); flag_clr_en = 1'b0;
        chk(flags == 5'b01010, "R6 zero no effect", {27'h0, flags}, 32'h0A);
        // R7: masking a live flag drops the request one cycle later
        chk(irq_out, "R7 irq live", {31'h0, irq_out}, 32'h1);
        write_ctrl(32'h0A00);
        chk(irq_out, "R7 irq one cycle late", {31'h0, irq_out}, 32'h1);
        cyc();
        chk(!irq_out, "R7 irq masked", {31'h0, irq_out}, 32'h0);

        // R10: write during stop
        write_ctrl(32'h1560);
        stop = 1'b1; wr_en = 1'b1; wr_data = 32'hFFFF_0A9F; cyc();
        stop = 1'b0; wr_en = 1'b0; wr_data = '0;
        chk(rd_data == 32'h0A00, "R10 write in stop", rd_data, 32'h0A00);

        // R8: software reset
        write_ctrl(32'h1F60);
        evt_set = 5'h1F; cyc(); evt_set = '0; cyc();
        sw_rst = 1'b1; cyc(); sw_rst = 1'b0;
        chk(rd_data == 32'h0, "R8 ctrl cleared", rd_data, 32'h0);
        chk(flags == 5'h0 && !irq_out, "R8 flags/irq", {26'h0, irq_out, flags}, 32'h0);
        chk(!uflo_recover_en && !lookahead_en, "R8 levels", {uflo_recover_en, lookahead_en}, 32'h0);

        // R1: hardware reset mid-run
        write_ctrl(32'h1F60);
        evt_set = 5'h1F; cyc(); evt_set = '0;
        hw_rst_n = 1'b0; cyc();
        chk(rd_data == 32'h0 && flags == 5'h0 && !irq_out, "R1 hw reset", rd_data, 32'h0);
        hw_rst_n = 1'b1; cyc();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog act=hung exp=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule